// File: doc/BRIEF.md
# Six-Channel Programmable Interval Timer

This block holds six independent down-counting timer channels behind a small synchronous register bus. Each channel picks one of four free-running clock-enable inputs, divides it by a power of two from 1 to 128, and counts its current value down by one on every divided tick. A channel can run periodically, refilling itself from its interval register after each expiry, or as a one-shot that stops and drops its own run bit after the first expiry.

Expiries are collected in a shared status register that software clears by writing ones. A shared enable register masks the status bits onto one interrupt line per channel, and the lines follow either register in the same cycle. Register reads are combinational from the address; writes land on the rising clock edge while the write strobe is high.

Top module: `ivt_timer_bank`

## Requirements
- R1: Channel n (0 to 5) answers at byte address (n+1)*0x10; within that window low nibble 0x0 is control, 0x4 is interval, 0x8 is count. The interrupt enable register is at 0x00 and the interrupt status register at 0x04, one bit per channel in bit n.
- R2: Control reads back the low 8 bits last written (bit 0 run, bit 1 reload request, bits 3:2 source select, bits 6:4 divide exponent k, bit 7 one-shot), with all higher bits zero.
- R3: A control write with bit 1 set copies the interval into the count; a control write with bit 1 clear leaves the count unchanged.
- R4: While running, the count falls by one every 2^k pulses of the selected source; on a divided tick that finds the count at zero the channel expires, so the first expiry comes (interval+1)*2^k pulses after the starting control write.
- R5: Only the clock-enable input chosen by control bits 3:2 advances a channel.
- R6: In periodic mode (bit 7 clear) an expiry refills the count from the interval and counting continues, so expiries repeat every (interval+1)*2^k pulses.
- R7: In one-shot mode (bit 7 set) an expiry clears control bit 0, leaves the count at zero and no further expiry follows.
- R8: A control write with bit 0 clear stops the channel: the count holds its value.
- R9: An expiry sets the channel's status bit; writing the status register clears each bit written as 1 and keeps bits written as 0; an expiry in the same cycle as its clearing write leaves the bit set.
- R10: Interrupt line n is high exactly when status bit n and enable bit n are both set, changing in the same cycle as either register.
- R11: Writes to a count register or to any unmapped address change nothing; reads of unmapped addresses return zero.
- R12: After reset the enable, status, every control, interval and count register read zero, all channels are stopped and all interrupt lines are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_en | input | 4 | Four clock-enable pulse sources selectable per channel |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq | output | 6 | Masked interrupt per channel |

## Verification
The collision that matters is a channel expiring on the very edge at which software writes a one to clear its status bit. The bench computes that edge as (interval+1)*2^k after the starting control write and schedules the clearing write to land on it, then expects the bit still set; a second clearing write one cycle away from any expiry must then drop it. A similar pairing checks that a stop write never coincides with a counter step, by comparing the count read just before the stop with the count read long after.

// File: rtl/ivt_pkg.sv
// Shared constants of the interval timer bank: register offsets and
// control field positions. Assumes 8-bit byte addressing of the bank.
package ivt_pkg;
    localparam int ADDR_W      = 8;
    localparam int SRC_N       = 4;
    localparam int SRC_W       = 2;
    localparam int EXP_W       = 3;
    localparam int CTL_W       = 8;

    localparam int CTL_EN      = 0;
    localparam int CTL_RELOAD  = 1;
    localparam int CTL_SRC_LSB = 2;
    localparam int CTL_EXP_LSB = 4;
    localparam int CTL_MODE    = 7;

    localparam logic [ADDR_W-1:0] ADR_IRQ_EN = 8'h00;
    localparam logic [ADDR_W-1:0] ADR_IRQ_ST = 8'h04;
    localparam logic [3:0]        SUB_CTRL   = 4'h0;
    localparam logic [3:0]        SUB_IVAL   = 4'h4;
    localparam logic [3:0]        SUB_CNT    = 4'h8;
endpackage

// File: rtl/ivt_prescaler.sv
// Power-of-two divider for one channel. Emits a one-cycle tick on every
// 2^exp_sel-th source enable. Assumes exp_sel only changes while restart
// is high; restart holds the divider at phase zero and masks the tick.
module ivt_prescaler #(
    parameter int EXP_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             src_en,
    input  logic [EXP_W-1:0] exp_sel,
    output logic             tick
);
    localparam int DIV_W = (1 << EXP_W) - 1;

    logic [DIV_W-1:0] phase_q;
    logic [DIV_W-1:0] limit;

    // Terminal phase: 2^exp_sel - 1 as a mask of low ones.
    always_comb begin
        limit = '0;
        for (int b = 0; b < DIV_W; b++) begin
            if (b < int'(exp_sel)) limit[b] = 1'b1;
        end
    end

    assign tick = src_en && !restart && (phase_q == limit);

    // Phase counter: advances on source enables, wraps at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            phase_q <= '0;
        end else if (src_en) begin
            phase_q <= (phase_q == limit) ? '0 : phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/ivt_channel.sv
// One timer channel: control, interval and live count registers plus
// its divider. Assumes ctrl_wr and ival_wr are never high together.
// expire pulses for one cycle when a divided tick finds the count at 0.
module ivt_channel
    import ivt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_N-1:0]  src_en,
    input  logic              ctrl_wr,
    input  logic              ival_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [CTL_W-1:0]  ctrl_q,
    output logic [DATA_W-1:0] ival_q,
    output logic [DATA_W-1:0] cnt_q,
    output logic              expire
);
    logic run;
    logic one_shot;
    logic src_sel;
    logic tick;

    assign run      = ctrl_q[CTL_EN];
    assign one_shot = ctrl_q[CTL_MODE];
    assign src_sel  = src_en[ctrl_q[CTL_SRC_LSB +: SRC_W]];
    assign expire   = run && tick && (cnt_q == '0);

    ivt_prescaler #(.EXP_W(EXP_W)) i_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (ctrl_wr || !run),
        .src_en  (src_sel),
        .exp_sel (ctrl_q[CTL_EXP_LSB +: EXP_W]),
        .tick    (tick)
    );

    // Control register: software write, or one-shot self-stop on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q <= wdata[CTL_W-1:0];
        end else if (expire && one_shot) begin
            ctrl_q[CTL_EN] <= 1'b0;
        end
    end

    // Interval register: plain software storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ival_q <= '0;
        end else if (ival_wr) begin
            ival_q <= wdata;
        end
    end

    // Down-counter: reload request, step on tick, refill or hold on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (ctrl_wr && wdata[CTL_RELOAD]) begin
            cnt_q <= ival_q;
        end else if (run && tick) begin
            if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end else if (!one_shot) begin
                cnt_q <= ival_q;
            end
        end
    end
endmodule

// File: rtl/ivt_timer_bank.sv
// Bank of NUM_CH interval timer channels with shared interrupt enable and
// write-one-to-clear status. Assumes NUM_CH <= 14 so every channel window
// fits the 8-bit map, and DATA_W >= CTL_W and >= NUM_CH.
module ivt_timer_bank
    import ivt_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_N-1:0]  src_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] irq
);
    logic [3:0]        win;
    logic [3:0]        sub;
    logic [NUM_CH-1:0] irq_en_q;
    logic [NUM_CH-1:0] irq_st_q;
    logic [NUM_CH-1:0] st_clr;
    logic [NUM_CH-1:0] expire_vec;
    logic [NUM_CH-1:0] run_vec;
    logic [NUM_CH-1:0] mode_vec;
    logic [CTL_W-1:0]  ctrl_arr [NUM_CH];
    logic [DATA_W-1:0] ival_arr [NUM_CH];
    logic [DATA_W-1:0] cnt_arr  [NUM_CH];

    assign win = bus_addr[7:4];
    assign sub = bus_addr[3:0];

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        logic hit;
        assign hit = (win == 4'(n + 1));

        ivt_channel #(.DATA_W(DATA_W)) i_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .src_en  (src_en),
            .ctrl_wr (bus_we && hit && (sub == SUB_CTRL)),
            .ival_wr (bus_we && hit && (sub == SUB_IVAL)),
            .wdata   (bus_wdata),
            .ctrl_q  (ctrl_arr[n]),
            .ival_q  (ival_arr[n]),
            .cnt_q   (cnt_arr[n]),
            .expire  (expire_vec[n])
        );

        assign run_vec[n]  = ctrl_arr[n][CTL_EN];
        assign mode_vec[n] = ctrl_arr[n][CTL_MODE];
    end

    assign st_clr = (bus_we && bus_addr == ADR_IRQ_ST) ? bus_wdata[NUM_CH-1:0] : '0;

    // Interrupt enable register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en_q <= '0;
        end else if (bus_we && bus_addr == ADR_IRQ_EN) begin
            irq_en_q <= bus_wdata[NUM_CH-1:0];
        end
    end

    // Status register: expiries set, written ones clear, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_st_q <= '0;
        end else begin
            irq_st_q <= (irq_st_q & ~st_clr) | expire_vec;
        end
    end

    // Masked interrupt lines, same-cycle with either register.
    assign irq = irq_st_q & irq_en_q;

    // Read path: decode address, zero for anything unmapped.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADR_IRQ_EN) begin
            bus_rdata[NUM_CH-1:0] = irq_en_q;
        end else if (bus_addr == ADR_IRQ_ST) begin
            bus_rdata[NUM_CH-1:0] = irq_st_q;
        end
        for (int n = 0; n < NUM_CH; n++) begin
            if (win == 4'(n + 1)) begin
                case (sub)
                    SUB_CTRL: bus_rdata[CTL_W-1:0] = ctrl_arr[n];
                    SUB_IVAL: bus_rdata = ival_arr[n];
                    SUB_CNT:  bus_rdata = cnt_arr[n];
                    default:  bus_rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/ivt_checker.sv
// Temporal checks on the timer bank's status, enable and channel run
// state. Attached to every ivt_timer_bank instance by the bind below.
module ivt_checker
    import ivt_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [NUM_CH-1:0] irq,
    input logic [NUM_CH-1:0] irq_en_q,
    input logic [NUM_CH-1:0] irq_st_q,
    input logic [NUM_CH-1:0] expire_vec,
    input logic [NUM_CH-1:0] run_vec,
    input logic [NUM_CH-1:0] mode_vec
);
    logic st_wr;
    assign st_wr = bus_we && (bus_addr == ADR_IRQ_ST);

    // R12: reset leaves everything quiet.
    a_r12_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (irq_st_q == '0) && (irq_en_q == '0) && (run_vec == '0));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_bit
        // R9: an expiry always leaves its status bit set, even against a clear.
        a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            expire_vec[i] |=> irq_st_q[i]);
        // R9: a written one clears the bit when no expiry coincides.
        a_r9_write_one_clears: assert property (@(posedge clk) disable iff (!rst_n)
            st_wr && bus_wdata[i] && !expire_vec[i] |=> !irq_st_q[i]);
        // R9: a set bit stays set unless cleared by a written one.
        a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            irq_st_q[i] && !(st_wr && bus_wdata[i]) |=> irq_st_q[i]);
        // R9: a status bit rises only after an expiry.
        a_r9_rise_from_expiry: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_st_q[i]) |-> $past(expire_vec[i]));
        // R7: a one-shot expiry drops the run bit.
        a_r7_oneshot_stops: assert property (@(posedge clk) disable iff (!rst_n)
            expire_vec[i] && mode_vec[i] |=> !run_vec[i]);
        // R10: masking takes effect in the same cycle the enable falls.
        a_r10_mask_immediate: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(irq_en_q[i]) |-> !irq[i]);
    end
endmodule

bind ivt_timer_bank ivt_checker #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) i_ivt_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .irq        (irq),
    .irq_en_q   (irq_en_q),
    .irq_st_q   (irq_st_q),
    .expire_vec (expire_vec),
    .run_vec    (run_vec),
    .mode_vec   (mode_vec)
);

// File: tb/test_ivt_timer_bank.sv
module test_ivt_timer_bank;
    localparam int NUM_CH = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  src_en = 4'b0011;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [5:0]  irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    // Source 3 toggles every cycle; sources 0 and 1 high, source 2 low.
    always @(negedge clk) src_en[3] <= ~src_en[3];

    ivt_timer_bank i_ivt_timer_bank (
        .clk(clk), .rst_n(rst_n), .src_en(src_en), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic int unsigned first_expiry(int unsigned ival, int unsigned k);
        return (ival + 1) << k;
    endfunction

    function automatic logic [31:0] count_after(int unsigned ival, int unsigned k, int unsigned edges);
        return 32'(ival - (edges >> k));
    endfunction

    function automatic logic [7:0] ctl(bit run, bit rl, int unsigned src, int unsigned k, bit oneshot);
        return {oneshot, 3'(k), 2'(src), rl, run};
    endfunction

    function automatic logic [7:0] chb(int unsigned ch, logic [3:0] sub);
        return {4'(ch + 1), sub};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Called at a falling edge; the write lands on the next rising edge.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_edges(input int unsigned n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [31:0] d, d2;
        int unsigned seed_sink;
        seed_sink = $urandom(32'd4711);
        wait_edges(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: reset state.
        rd(8'h00, d); chk("R12 enable", d, 0);
        rd(8'h04, d); chk("R12 status", d, 0);
        for (int c = 0; c < NUM_CH; c++) begin
            rd(chb(c, 4'h0), d); chk("R12 control", d, 0);
            rd(chb(c, 4'h4), d); chk("R12 interval", d, 0);
            rd(chb(c, 4'h8), d); chk("R12 count", d, 0);
        end
        chk("R12 irq", 32'(irq), 0);

        // R1: distinct intervals per channel read back from their windows.
        for (int c = 0; c < NUM_CH; c++) wr(chb(c, 4'h4), 32'h1000_0000 + 32'(c * 17));
        for (int c = 0; c < NUM_CH; c++) begin
            rd(chb(c, 4'h4), d); chk("R1 interval map", d, 32'h1000_0000 + 32'(c * 17));
        end
        wr(8'h00, 32'h3F); rd(8'h00, d); chk("R1 enable map", d, 32'h3F);
        wr(8'h00, 32'h0);

        // R2: control readback of low byte, run bit kept clear.
        d2 = $urandom() & 32'hFFFF_FFFE;
        wr(chb(2, 4'h0), d2); rd(chb(2, 4'h0), d); chk("R2 control readback", d, 32'(d2[7:0]));

        // R3: reload copies interval; no reload keeps count.
        wr(chb(4, 4'h4), 32'd77);
        wr(chb(4, 4'h0), 32'(ctl(0, 1, 0, 0, 0)));
        rd(chb(4, 4'h8), d); chk("R3 reload", d, 77);
        wr(chb(4, 4'h4), 32'd5);
        wr(chb(4, 4'h0), 32'(ctl(0, 0, 0, 0, 0)));
        rd(chb(4, 4'h8), d); chk("R3 no reload", d, 77);

        // R11: count writes and unmapped writes ignored, unmapped reads zero.
        wr(chb(4, 4'h8), 32'h55);
        rd(chb(4, 4'h8), d); chk("R11 count write ignored", d, 77);
        wr(8'h08, 32'h3F); rd(8'h00, d); chk("R11 unmapped write", d, 0);
        wr(chb(4, 4'hC), 32'h99); rd(chb(4, 4'h4), d); chk("R11 window hole write", d, 5);
        rd(chb(4, 4'hC), d); chk("R11 hole read", d, 0);
        rd(8'h7C, d); chk("R11 beyond map read", d, 0);
        rd(8'h02, d); chk("R11 low hole read", d, 0);

        // R4 R6 R7: random channels, intervals, exponents and modes on source 0.
        for (int it = 0; it < 12; it++) begin
            int unsigned c, iv, k, x, n;
            bit os;
            c = $urandom_range(0, NUM_CH - 1);
            iv = $urandom_range(1, 20);
            k = $urandom_range(0, 3);
            os = 1'($urandom_range(0, 1));
            x = first_expiry(iv, k);
            wr(chb(c, 4'h4), iv);
            wr(chb(c, 4'h0), 32'(ctl(1, 1, 0, k, os)));
            n = $urandom_range(1, x - 1);
            wait_edges(n);
            rd(chb(c, 4'h8), d); chk("R4 count mid-run", d, count_after(iv, k, n));
            wait_edges(x - 1 - n);
            rd(8'h04, d); chk("R4 before expiry", 32'(d[c]), 0);
            wait_edges(1);
            rd(8'h04, d); chk("R4 at expiry", 32'(d[c]), 1);
            wr(8'h04, 32'(1 << c));
            if (os) begin
                rd(chb(c, 4'h0), d); chk("R7 run bit cleared", 32'(d[0]), 0);
                rd(chb(c, 4'h8), d); chk("R7 count at zero", d, 0);
                wait_edges(2 * x);
                rd(8'h04, d); chk("R7 no second expiry", 32'(d[c]), 0);
            end else begin
                rd(chb(c, 4'h8), d); chk("R6 refilled", d, count_after(iv, k, 1));
                wait_edges(x - 2);
                rd(8'h04, d); chk("R6 before second expiry", 32'(d[c]), 0);
                wait_edges(1);
                rd(8'h04, d); chk("R6 second expiry", 32'(d[c]), 1);
                wr(chb(c, 4'h0), 32'(ctl(0, 0, 0, k, 0)));
                wr(8'h04, 32'(1 << c));
            end
        end

        // R5: source 2 held low freezes; toggling source 3 gives half rate.
        wr(chb(1, 4'h4), 32'd100);
        wr(chb(1, 4'h0), 32'(ctl(1, 1, 2, 0, 0)));
        wait_edges(20);
        rd(chb(1, 4'h8), d); chk("R5 idle source", d, 100);
        wr(chb(1, 4'h0), 32'(ctl(1, 1, 3, 0, 0)));
        wait_edges(40);
        rd(chb(1, 4'h8), d); chk("R5 toggling source", d, 80);

        // R8: stopping holds the count.
        wr(chb(1, 4'h0), 32'(ctl(1, 1, 1, 1, 0)));
        wait_edges(13);
        rd(chb(1, 4'h8), d2);
        wr(chb(1, 4'h0), 32'(ctl(0, 0, 1, 1, 0)));
        wait_edges(30);
        rd(chb(1, 4'h8), d); chk("R8 frozen count", d, d2);
        chk("R8 count before stop", d2, count_after(100, 1, 13));

        // R9: clear write on the expiry edge loses to the expiry.
        wr(chb(3, 4'h4), 32'd3);
        wr(chb(3, 4'h0), 32'(ctl(1, 1, 0, 0, 0)));
        wait_edges(first_expiry(3, 0) - 1);
        wr(8'h04, 32'h3F);
        rd(8'h04, d); chk("R9 set beats clear", 32'(d[3]), 1);
        wr(8'h04, 32'h0);
        rd(8'h04, d); chk("R9 zero write keeps", 32'(d[3]), 1);
        wr(8'h04, 32'(1 << 3));
        rd(8'h04, d); chk("R9 one write clears", 32'(d[3]), 0);
        wr(chb(3, 4'h0), 32'(ctl(0, 0, 0, 0, 0)));
        wr(8'h04, 32'h3F);

        // R10: masking of a one-shot expiry.
        wr(chb(5, 4'h4), 32'd2);
        wr(chb(5, 4'h0), 32'(ctl(1, 1, 0, 0, 1)));
        wait_edges(first_expiry(2, 0));
        rd(8'h04, d); chk("R10 status set", 32'(d[5]), 1);
        chk("R10 masked line", 32'(irq[5]), 0);
        wr(8'h00, 32'(1 << 5));
        chk("R10 line follows enable", 32'(irq), 32'(1 << 5));
        wr(8'h00, 32'h0);
        chk("R10 line drops with enable", 32'(irq[5]), 0);
        wr(8'h00, 32'(1 << 5));
        wr(8'h04, 32'(1 << 5));
        chk("R10 line drops with status", 32'(irq[5]), 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule